// File: doc/BRIEF.md
# Cascadable BCD Up/Down Decade Counter

This block holds one decimal digit of a clock, timer or event counter. On each rising clock edge it either clears, takes a parallel preset, steps one place up or down through the decimal range 0 to 9, or keeps its value. The wrap between 9 and 0 is decoded inside the block, so a decade never needs outside gating to stay in BCD.

Decades are chained by feeding the active-low carry-out of one digit into the active-low count enable of the next. All digits share one clock, and the next digit steps on the same edge that wraps the lower one. In down mode, an inverted carry-out can be fed back into the load input with a preset on the parallel inputs. The digit then runs as a modulo-(preset+1) down-counter.

If a code from 10 to 15 gets into the register, for example through the preset path, the next counting edge brings it back into the decimal range.

Top module: `bcd_updown_counter`

## Requirements
- R1: `rst` high at a rising edge sets `count` to 0, whatever `load`, `carry_in_n` and `up_dn` are.
- R2: With `rst` low, `load` high at a rising edge copies `preset` into `count` unchanged, including codes 10 to 15. It takes effect whatever `carry_in_n` is, and it takes priority over counting.
- R3: With `rst` and `load` low, `carry_in_n` high at a rising edge leaves `count` unchanged.
- R4: With `rst`, `load` and `carry_in_n` low and `up_dn` = 1, a legal `count` of 0 to 8 goes up by one at the edge, and 9 goes to 0.
- R5: With `rst`, `load` and `carry_in_n` low and `up_dn` = 0, a legal `count` of 1 to 9 goes down by one at the edge, and 0 goes to 9.
- R6: A counting edge that starts from a code of 10 to 15 gives 0 when `up_dn` = 1 and 9 when `up_dn` = 0. The digit is therefore legal after one edge, which is within the two-edge recovery bound.
- R7: `carry_out_n` is combinational and active-low. It is 0 only while `carry_in_n` is 0 and either `up_dn` = 1 with `count` = 9, or `up_dn` = 0 with `count` = 0. It is 1 for every code from 10 to 15.
- R8: Two digits on one clock, with the upper digit's `carry_in_n` driven by the lower digit's `carry_out_n`, count 00 to 99 and wrap to 00 in up mode. In down mode they count 99 down to 00 and wrap to 99.
- R9: In down mode, with `load` driven by the inverse of `carry_out_n` and a preset P from 0 to 9, the digit repeats the cycle P, P-1, …, 0. The edge taken at 0 loads P, so the cycle has a period of P+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| load | input | 1 | Synchronous parallel load, active high |
| carry_in_n | input | 1 | Count enable, active low |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| preset | input | W | Parallel load value |
| count | output | W | Current BCD digit |
| carry_out_n | output | 1 | Terminal-count flag for the next decade, active low |

## Verification
Two functions can fall in the same cycle. The first pair is the terminal-count wrap and the parallel load. In the modulo loop the digit sits at 0 with carry-out asserted, and that carry-out raises load, so the edge must take the preset instead of wrapping to 9. The bench closes that loop with several presets and compares each edge against a reference sequence. The second pair is an upper decade stepping on the edge where the lower one wraps. The two-digit chain is run through all 100 values in each direction and checked after every edge.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        op_e  op;
        dir_e dir;
    } ctl_t;

endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
    import bcd_ctr_pkg::*;
(
    input  logic rst,
    input  logic load,
    input  logic carry_in_n,
    input  logic up_dn,
    output ctl_t ctl
);
    always_comb begin
        ctl.dir = up_dn ? DIR_UP : DIR_DOWN;
        if (rst)
            ctl.op = OP_CLEAR;
        else if (load)
            ctl.op = OP_LOAD;
        else if (!carry_in_n)
            ctl.op = OP_COUNT;
        else
            ctl.op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_step.sv
module bcd_step
    import bcd_ctr_pkg::*;
#(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] LAST_V = LAST[W-1:0];
    localparam logic [W-1:0] ZERO   = '0;
    localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

    logic legal;
    logic [W-1:0] up_val;
    logic [W-1:0] dn_val;

    assign legal = (cur <= LAST_V);

    always_comb begin
        if (!legal || cur == LAST_V)
            up_val = ZERO;
        else
            up_val = cur + ONE;

        if (!legal || cur == ZERO)
            dn_val = LAST_V;
        else
            dn_val = cur - ONE;

        nxt = (dir == DIR_UP) ? up_val : dn_val;
    end
endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect
    import bcd_ctr_pkg::*;
#(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    input  logic         carry_in_n,
    output logic         carry_out_n
);
    localparam logic [W-1:0] LAST_V = LAST[W-1:0];

    logic at_end;

    always_comb begin
        if (dir == DIR_UP)
            at_end = (cur == LAST_V);
        else
            at_end = (cur == '0);
        carry_out_n = ~(at_end & ~carry_in_n);
    end
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
    import bcd_ctr_pkg::*;
#(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         carry_in_n,
    input  logic         up_dn,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         carry_out_n
);
    ctl_t         ctl;
    logic [W-1:0] step_val;
    logic [W-1:0] digit_q;

    bcd_op_decode u_decode (
        .rst        (rst),
        .load       (load),
        .carry_in_n (carry_in_n),
        .up_dn      (up_dn),
        .ctl        (ctl)
    );

    bcd_step #(.W(W), .LAST(LAST)) u_step (
        .cur (digit_q),
        .dir (ctl.dir),
        .nxt (step_val)
    );

    bcd_term_detect #(.W(W), .LAST(LAST)) u_term (
        .cur         (digit_q),
        .dir         (ctl.dir),
        .carry_in_n  (carry_in_n),
        .carry_out_n (carry_out_n)
    );

    always_ff @(posedge clk) begin
        case (ctl.op)
            OP_CLEAR: digit_q <= '0;
            OP_LOAD:  digit_q <= preset;
            OP_COUNT: digit_q <= step_val;
            default:  digit_q <= digit_q;
        endcase
    end

    assign count = digit_q;
endmodule

// File: rtl/bcd_updown_counter_chk.sv
module bcd_updown_counter_chk #(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic         carry_in_n,
    input logic         up_dn,
    input logic [W-1:0] preset,
    input logic [W-1:0] count,
    input logic         carry_out_n
);
    localparam logic [W-1:0] LAST_V = LAST[W-1:0];
    localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

    logic counting;
    assign counting = !rst && !load && !carry_in_n;

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> count == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(preset));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && carry_in_n) |=> $stable(count));

    assert_up_step_R4: assert property (@(posedge clk) disable iff (rst)
        (counting && up_dn && count < LAST_V) |=> count == $past(count) + ONE);

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (counting && up_dn && count == LAST_V) |=> count == '0);

    assert_down_step_R5: assert property (@(posedge clk) disable iff (rst)
        (counting && !up_dn && count != '0 && count <= LAST_V) |=> count == $past(count) - ONE);

    assert_down_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (counting && !up_dn && count == '0) |=> count == LAST_V);

    assert_recover_R6: assert property (@(posedge clk) disable iff (rst)
        (counting && count > LAST_V) |=> count <= LAST_V);

    assert_carry_idle_R7: assert property (@(posedge clk) disable iff (rst)
        carry_in_n |-> carry_out_n);

    assert_carry_term_R7: assert property (@(posedge clk) disable iff (rst)
        !carry_out_n |-> (up_dn ? count == LAST_V : count == '0));
endmodule

bind bcd_updown_counter bcd_updown_counter_chk #(.W(W), .LAST(LAST)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .carry_in_n  (carry_in_n),
    .up_dn       (up_dn),
    .preset      (preset),
    .count       (count),
    .carry_out_n (carry_out_n)
);

// File: tb/test_bcd_updown_counter.sv
module test_bcd_updown_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drv_load = 1'b0;
    logic       lo_ci_n = 1'b1;
    logic       up_dn = 1'b1;
    logic       mod_mode = 1'b0;
    logic [3:0] lo_pre = 4'd0;
    logic [3:0] hi_pre = 4'd0;
    logic [3:0] lo_q, hi_q;
    logic       lo_co_n, hi_co_n;
    logic       lo_load;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign lo_load = mod_mode ? ~lo_co_n : drv_load;

    bcd_updown_counter i_bcd_updown_counter (
        .clk(clk), .rst(rst), .load(lo_load), .carry_in_n(lo_ci_n),
        .up_dn(up_dn), .preset(lo_pre), .count(lo_q), .carry_out_n(lo_co_n)
    );

    bcd_updown_counter i_hi (
        .clk(clk), .rst(rst), .load(drv_load), .carry_in_n(lo_co_n),
        .up_dn(up_dn), .preset(hi_pre), .count(hi_q), .carry_out_n(hi_co_n)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; drv_load = 1'b1; lo_pre = 4'd7; lo_ci_n = 1'b0;
        step();
        chk("R1 clear over load", lo_q, 0);
        rst = 1'b0; drv_load = 1'b0; lo_ci_n = 1'b1;
    endtask

    task automatic t_load();
        drv_load = 1'b1; lo_ci_n = 1'b0; lo_pre = 4'd6; up_dn = 1'b1;
        step();
        chk("R2 load over count", lo_q, 6);
        lo_ci_n = 1'b1; lo_pre = 4'd3;
        step();
        chk("R2 load with enable high", lo_q, 3);
        lo_pre = 4'd12;
        step();
        chk("R2 raw illegal load", lo_q, 12);
        drv_load = 1'b0;
    endtask

    task automatic t_hold();
        lo_ci_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            up_dn = i[0];
            step();
            chk("R3 hold", lo_q, 12);
        end
    endtask

    task automatic t_up();
        int e;
        rst = 1'b1; step(); rst = 1'b0;
        up_dn = 1'b1; lo_ci_n = 1'b0; e = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            e = (e == 9) ? 0 : e + 1;
            chk("R4 up count", lo_q, e);
        end
        lo_ci_n = 1'b1;
    endtask

    task automatic t_down();
        int e;
        rst = 1'b1; step(); rst = 1'b0;
        up_dn = 1'b0; lo_ci_n = 1'b0; e = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            e = (e == 0) ? 9 : e - 1;
            chk("R5 down count", lo_q, e);
        end
        lo_ci_n = 1'b1;
    endtask

    task automatic t_illegal();
        for (int c = 10; c < 16; c++) begin
            for (int d = 0; d < 2; d++) begin
                drv_load = 1'b1; lo_ci_n = 1'b1; lo_pre = 4'(c); up_dn = d[0];
                step();
                chk("R6 illegal preload", lo_q, c);
                chk("R7 no carry on illegal", lo_co_n, 1);
                drv_load = 1'b0; lo_ci_n = 1'b0;
                #1;
                chk("R7 no carry on illegal enabled", lo_co_n, 1);
                step();
                chk("R6 recovery", lo_q, (d == 1) ? 0 : 9);
            end
        end
        lo_ci_n = 1'b1;
    endtask

    task automatic t_carry();
        drv_load = 1'b1; lo_ci_n = 1'b1; lo_pre = 4'd9; up_dn = 1'b1;
        step();
        drv_load = 1'b0;
        chk("R7 carry gated by enable", lo_co_n, 1);
        lo_ci_n = 1'b0; #1;
        chk("R7 carry at 9 up", lo_co_n, 0);
        up_dn = 1'b0; #1;
        chk("R7 no carry at 9 down", lo_co_n, 1);
        lo_ci_n = 1'b1;
        drv_load = 1'b1; lo_pre = 4'd0;
        step();
        drv_load = 1'b0; lo_ci_n = 1'b0; #1;
        chk("R7 carry at 0 down", lo_co_n, 0);
        up_dn = 1'b1; #1;
        chk("R7 no carry at 0 up", lo_co_n, 1);
        lo_ci_n = 1'b1;
    endtask

    task automatic t_cascade();
        int e;
        rst = 1'b1; step(); rst = 1'b0;
        up_dn = 1'b1; lo_ci_n = 1'b0; e = 0;
        for (int i = 0; i < 101; i++) begin
            step();
            e = (e + 1) % 100;
            chk("R8 chain up", hi_q * 10 + lo_q, e);
        end
        up_dn = 1'b0;
        for (int i = 0; i < 102; i++) begin
            step();
            e = (e + 99) % 100;
            chk("R8 chain down", hi_q * 10 + lo_q, e);
        end
        lo_ci_n = 1'b1;
    endtask

    task automatic t_modulo(input int p);
        int e;
        rst = 1'b1; step(); rst = 1'b0;
        up_dn = 1'b0; lo_ci_n = 1'b0; lo_pre = 4'(p); mod_mode = 1'b1; e = 0;
        for (int i = 0; i < 2 * (p + 1) + 2; i++) begin
            step();
            e = (e == 0) ? p : e - 1;
            chk("R9 modulo loop", lo_q, e);
        end
        mod_mode = 1'b0; lo_ci_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_load();
        t_hold();
        t_up();
        t_down();
        t_illegal();
        t_carry();
        t_cascade();
        t_modulo(5);
        t_modulo(3);
        t_modulo(9);
        t_modulo(0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule